// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the write-command side of a parallel NOR flash on a small register array. Bus cycles qualified by active-low chip enable, write enable and output enable are interpreted as a command language. That language covers four-cycle word program, six-cycle sector erase, erase suspend and resume, a bypass mode that shortens program to two cycles, and a return to read mode. Program and erase are timed internally by cycle counters. Erase is run in two steps: every word of the sector is first driven to all zeros, then the whole sector is set to all ones.

While an operation is running, the ready output is low and reads return a status byte instead of array data. Bit 7 of that byte is the complement of the data being programmed, and bit 6 flips on every read. A per-sector protect vector and a low-supply inhibit input block changes. The active-low reset aborts whatever is running.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After reset, rdy is 1, the machine is in read mode, and rdata is 0 whenever a read is not enabled.
- R2: The write sequence AA@555h, 55@2AAh, A0@555h, then data at a target address programs that word. Program only clears bits: the result is the old word ANDed with the data. rdy is low for exactly PROG_CYC cycles, counted from the data write.
- R3: A read while busy returns status. Bit 7 is the complement of bit 7 of the program data, or 0 during erase. Bit 6 inverts on each successive read. Bits 5..0 are 0.
- R4: rdy is low from the clock edge that starts a program or erase until it completes. While busy, every write except the suspend byte is ignored.
- R5: The write sequence AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, then 30 at any address in a sector erases that sector. The sector is addr[5:4]. rdy is low for SECD+ERASE_CYC cycles. Afterwards every word of the sector reads FFh and the other sectors are unchanged.
- R6: The erase first writes 00h to the sector's words one per cycle, from the lowest address upward, and only then erases.
- R7: Writing B0h during an erase suspends it at once: rdy goes high and reads return array contents. Writing 30h in read mode while suspended resumes the erase from where it stopped.
- R8: While an erase is suspended, words in other sectors can be programmed. A program aimed at the suspended sector has no effect.
- R9: The write sequence AA@555h, 55@2AAh, 20@555h enters bypass mode. In bypass mode a program takes two writes: A0h, then data at the target. The pair 90h, 00h leaves bypass mode.
- R10: A write that breaks an unlock sequence returns the machine to read mode.
- R11: A program or erase aimed at a sector whose prot bit is set changes nothing, and rdy stays high.
- R12: While lowv is 1, all writes are ignored.
- R13: Driving rst_n low aborts any operation. Afterwards rdy is high, reads return array data, and words already written keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, aborts operations |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lowv | input | 1 | Low-supply detect, inhibits writes |
| prot | input | NSEC | Per-sector protect flags |
| addr | input | AW | Bus address, low MW bits select the word |
| wdata | input | DW | Write data or command byte |
| rdata | output | DW | Array data, status byte, or 0 when not reading |
| rdy | output | 1 | High when ready, low while busy |

## Verification
A write is taken at the clock edge where it is presented. A read returns its value in the same cycle, and the status toggle advances at the edge that closes the read. A program keeps rdy low for exactly PROG_CYC cycles after the data write, and an erase for SECD+ERASE_CYC cycles. A resumed erase runs for its remaining count, where the edge that resumes it does not itself advance. The bench samples rdy and rdata at the falling edge and counts the low-rdy samples, comparing each count to these formulas rather than simply waiting for completion. The words already preprogrammed at a suspend or a reset are predicted from the number of edges that have passed since the erase began.

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int MW = 6,
  parameter int SW = 2,
  parameter int PROG_CYC = 6,
  parameter int ERASE_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            lowv,
  input  logic [(1<<SW)-1:0] prot,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            rdy
);
  localparam int OW    = MW - SW;
  localparam int SECD  = 1 << OW;
  localparam int DEPTH = 1 << MW;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);

  typedef enum logic [3:0] {C_RD, C_U1, C_U2, C_PG, C_E1, C_E2, C_E3, C_BY, C_BYP, C_BYX} cmd_t;

  cmd_t cmd;
  logic [DW-1:0] mem [DEPTH];
  logic pgm_busy, ers_act, ephase, susp, tog;
  logic [PCW-1:0] pcnt;
  logic [MW-1:0]  paddr;
  logic [DW-1:0]  pdata;
  logic [SW-1:0]  esec;
  logic [OW-1:0]  eidx;
  logic [ECW-1:0] ecnt;
  logic [DW-1:0]  status;

  wire rd = !ce_n && !oe_n && we_n;
  wire wr = !ce_n && !we_n && oe_n && !lowv;
  wire [MW-1:0] maddr = addr[MW-1:0];
  wire [SW-1:0] wsec = maddr[MW-1:OW];
  wire [7:0] cb = wdata[7:0];
  wire at555 = addr == AW'('h555);
  wire at2aa = addr == AW'('h2AA);

  wire busy     = pgm_busy || (ers_act && !susp);
  wire ers_run  = ers_act && !susp && !pgm_busy;
  wire accept   = wr && !busy;
  wire pg_ok    = !prot[wsec] && !(susp && wsec == esec);
  wire pg_arm   = (cmd == C_PG) || (cmd == C_BYP);
  wire pg_fire  = pgm_busy && pcnt == '0;
  wire pre_fire = ers_run && !ephase;
  wire fill     = ers_run && ephase && ecnt == '0;

  assign rdy = !busy;

  always_comb begin
    status = '0;
    status[7] = pgm_busy ? ~pdata[7] : 1'b0;
    status[6] = tog;
  end

  assign rdata = !rd ? '0 : (busy ? status : mem[maddr]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= C_RD;
      pgm_busy <= 1'b0;
      ers_act <= 1'b0;
      ephase <= 1'b0;
      susp <= 1'b0;
      tog <= 1'b0;
      pcnt <= '0;
      paddr <= '0;
      pdata <= '0;
      esec <= '0;
      eidx <= '0;
      ecnt <= '0;
    end else begin
      if (rd && busy) tog <= ~tog;
      if (pgm_busy) begin
        if (pcnt == '0) pgm_busy <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end
      if (ers_run) begin
        if (!ephase) begin
          eidx <= eidx + 1'b1;
          if (eidx == OW'(SECD - 1)) begin
            ephase <= 1'b1;
            ecnt <= ECW'(ERASE_CYC - 1);
          end
        end else if (ecnt == '0) ers_act <= 1'b0;
        else ecnt <= ecnt - 1'b1;
      end
      if (ers_act && !susp && wr && cb == 8'hB0) susp <= 1'b1;
      if (accept) begin
        case (cmd)
          C_RD: begin
            if (at555 && cb == 8'hAA) cmd <= C_U1;
            else if (susp && cb == 8'h30) susp <= 1'b0;
          end
          C_U1: cmd <= (at2aa && cb == 8'h55) ? C_U2 : C_RD;
          C_U2: begin
            if (at555 && cb == 8'hA0) cmd <= C_PG;
            else if (at555 && cb == 8'h80 && !susp) cmd <= C_E1;
            else if (at555 && cb == 8'h20 && !susp) cmd <= C_BY;
            else cmd <= C_RD;
          end
          C_PG, C_BYP: begin
            if (pg_ok) begin
              pgm_busy <= 1'b1;
              pcnt <= PCW'(PROG_CYC - 1);
              paddr <= maddr;
              pdata <= wdata;
            end
            cmd <= (cmd == C_PG) ? C_RD : C_BY;
          end
          C_E1: cmd <= (at555 && cb == 8'hAA) ? C_E2 : C_RD;
          C_E2: cmd <= (at2aa && cb == 8'h55) ? C_E3 : C_RD;
          C_E3: begin
            if (cb == 8'h30 && !prot[wsec]) begin
              ers_act <= 1'b1;
              ephase <= 1'b0;
              eidx <= '0;
              esec <= wsec;
            end
            cmd <= C_RD;
          end
          C_BY: begin
            if (cb == 8'hA0) cmd <= C_BYP;
            else if (cb == 8'h90) cmd <= C_BYX;
          end
          C_BYX: cmd <= (cb == 8'h00) ? C_RD : C_BY;
          default: cmd <= C_RD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pg_fire) mem[paddr] <= mem[paddr] & pdata;
    if (pre_fire) mem[{esec, eidx}] <= '0;
    if (fill)
      for (int i = 0; i < SECD; i++) mem[{esec, OW'(i)}] <= '1;
  end
endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk #(
  parameter int DW = 8,
  parameter int SW = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic lowv,
  input logic rdy,
  input logic pg_arm,
  input logic ers_act,
  input logic susp,
  input logic tog,
  input logic [(1<<SW)-1:0] prot,
  input logic [SW-1:0] sec,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata
);
  wire rd = !ce_n && !oe_n && we_n;
  wire wr = !ce_n && !we_n && oe_n && !lowv;

  a_r13_reset_ready: assert property (@(posedge clk) !rst_n |=> rdy);

  a_r12_lowv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && lowv) |=> rdy);

  a_r3_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !rdy) |-> ((rdata & DW'(8'h3F)) == '0));

  a_r3_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !rdy) |=> (tog != $past(tog)));

  a_r11_protect_block: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rdy && pg_arm && prot[sec]) |=> rdy);

  a_r7_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ers_act && !susp && wdata[7:0] == 8'hB0) |=> rdy);
endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .lowv(lowv), .rdy(rdy), .pg_arm(pg_arm), .ers_act(ers_act),
  .susp(susp), .tog(tog), .prot(prot), .sec(wsec),
  .wdata(wdata), .rdata(rdata)
);

// File: tb/tb_nor_cmd_fsm.sv
module tb_nor_cmd_fsm;
  localparam int PC = 6;
  localparam int EC = 20;
  localparam int SD = 16;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, lowv = 0;
  logic [3:0] prot = '0;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdy;
  int nchk = 0, nfail = 0;

  nor_cmd_fsm #(.PROG_CYC(PC), .ERASE_CYC(EC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lowv(lowv), .prot(prot), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdy(rdy));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 0; we_n = 0;
    @(posedge clk); #1;
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0;
    #5 d = rdata;
    @(posedge clk); #1;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [10:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [10:0] a);
    unlock(); wr(11'h555, 8'h80); unlock(); wr(a, 8'h30);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    @(negedge clk);
    while (!rdy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rdy after reset", rdy, 1);
    chk("R1 rdata idle", rdata, 8'h00);
  endtask

  task automatic t_erase_all();
    int n; logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      erase(11'(s * SD));
      wait_rdy(n);
      if (s == 0) chk("R5 erase busy cycles", n, SD + EC);
    end
    rd(11'h00, d); chk("R5 erased word", d, 8'hFF);
    rd(11'h3F, d); chk("R5 erased last word", d, 8'hFF);
  endtask

  task automatic t_program();
    int n; logic [7:0] d;
    prog(11'h05, 8'h3C);
    @(negedge clk); chk("R4 rdy low after program", rdy, 0);
    n = 1; while (!rdy && n < 2000) begin n++; @(negedge clk); end
    n = n - 1;
    chk("R2 program busy cycles", n, PC);
    rd(11'h05, d); chk("R2 programmed word", d, 8'h3C);
    prog(11'h05, 8'hF0); wait_rdy(n);
    rd(11'h05, d); chk("R2 program clears bits only", d, 8'h30);
  endtask

  task automatic t_status();
    int n; logic [7:0] a, b, d;
    prog(11'h06, 8'h5A);
    rd(11'h06, a); rd(11'h06, b);
    chk("R3 data polling bit7", a[7], 1);
    chk("R3 low status bits", a[5:0], 0);
    chk("R3 toggle differs", a[6] ^ b[6], 1);
    wr(11'h555, 8'hAA);
    wait_rdy(n);
    rd(11'h06, d); chk("R3 final data", d, 8'h5A);
    wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h0A, 8'h00);
    @(negedge clk); chk("R4 write while busy ignored rdy", rdy, 1);
    rd(11'h0A, d); chk("R4 write while busy ignored data", d, 8'hFF);
  endtask

  task automatic t_unexpected();
    logic [7:0] d;
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h12);
    wr(11'h555, 8'hA0); wr(11'h07, 8'h00);
    @(negedge clk); chk("R10 no program after broken unlock", rdy, 1);
    rd(11'h07, d); chk("R10 word unchanged", d, 8'hFF);
  endtask

  task automatic t_lowv();
    logic [7:0] d;
    lowv = 1;
    prog(11'h08, 8'h00);
    @(negedge clk); chk("R12 lowv rdy", rdy, 1);
    rd(11'h08, d); chk("R12 lowv word unchanged", d, 8'hFF);
    lowv = 0;
  endtask

  task automatic t_protect();
    int n; logic [7:0] d;
    prog(11'h21, 8'h11); wait_rdy(n);
    prot = 4'b0100;
    prog(11'h21, 8'h00);
    @(negedge clk); chk("R11 protected program rdy", rdy, 1);
    rd(11'h21, d); chk("R11 protected program data", d, 8'h11);
    erase(11'h20);
    @(negedge clk); chk("R11 protected erase rdy", rdy, 1);
    rd(11'h21, d); chk("R11 protected erase data", d, 8'h11);
    prot = 4'b0000;
  endtask

  task automatic t_erase_iso();
    int n; logic [7:0] a, b, d;
    prog(11'h12, 8'h77); wait_rdy(n);
    erase(11'h00);
    rd(11'h00, a); rd(11'h00, b);
    chk("R3 erase status bit7", a[7], 0);
    chk("R3 erase toggle", a[6] ^ b[6], 1);
    wait_rdy(n);
    rd(11'h05, d); chk("R5 sector0 erased", d, 8'hFF);
    rd(11'h12, d); chk("R5 sector1 untouched", d, 8'h77);
  endtask

  task automatic t_suspend();
    int n; logic [7:0] d;
    prog(11'h13, 8'h66); wait_rdy(n);
    erase(11'h10);
    wr(11'h000, 8'hB0);
    @(negedge clk); chk("R7 suspend rdy", rdy, 1);
    rd(11'h10, d); chk("R6 lowest word preprogrammed", d, 8'h00);
    rd(11'h11, d); chk("R6 next word not yet", d, 8'hFF);
    rd(11'h13, d); chk("R7 suspended read array", d, 8'h66);
    prog(11'h25, 8'h44); wait_rdy(n);
    chk("R8 program during suspend cycles", n, PC);
    rd(11'h25, d); chk("R8 other sector programmed", d, 8'h44);
    prog(11'h14, 8'h00);
    @(negedge clk); chk("R8 suspended sector program rdy", rdy, 1);
    rd(11'h14, d); chk("R8 suspended sector unchanged", d, 8'hFF);
    wr(11'h000, 8'h30);
    wait_rdy(n);
    chk("R7 resumed erase cycles", n, SD - 1 + EC);
    rd(11'h13, d); chk("R7 erase completed", d, 8'hFF);
    rd(11'h25, d); chk("R8 other sector kept", d, 8'h44);
  endtask

  task automatic t_bypass();
    int n; logic [7:0] d;
    unlock(); wr(11'h555, 8'h20);
    wr(11'h000, 8'hA0); wr(11'h30, 8'h99);
    wait_rdy(n);
    chk("R9 bypass program cycles", n, PC);
    rd(11'h30, d); chk("R9 bypass programmed", d, 8'h99);
    wr(11'h000, 8'h90); wr(11'h000, 8'h00);
    wr(11'h000, 8'hA0); wr(11'h31, 8'h00);
    @(negedge clk); chk("R9 bypass exited rdy", rdy, 1);
    rd(11'h31, d); chk("R9 bypass exited data", d, 8'hFF);
  endtask

  task automatic t_reset_abort();
    int n; logic [7:0] d;
    erase(11'h30);
    repeat (5) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R13 rdy after abort", rdy, 1);
    rd(11'h30, d); chk("R13 preprogrammed word kept", d, 8'h00);
    rd(11'h3F, d); chk("R13 untouched word kept", d, 8'hFF);
    prog(11'h3F, 8'h12); wait_rdy(n);
    rd(11'h3F, d); chk("R13 program after abort", d, 8'h12);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_erase_all();
    t_program();
    t_status();
    t_unexpected();
    t_lowv();
    t_protect();
    t_erase_iso();
    t_suspend();
    t_bypass();
    t_reset_abort();
    finish_run();
  end
endmodule